// File: doc/BRIEF.md
# Keyed Interval Watchdog Timer

This peripheral sits on a 16-bit microcontroller register bus and provides a periodic time base. A free-running 16-bit counter advances once per clock while interval operation is selected and the hold control is clear. Each time the counter completes the selected period (64, 512, 8192 or 32768 clocks), an interval flag is set. An interrupt request goes to the CPU when that flag and a separate enable bit are both set.

The control register is protected by a key. A write changes the control register only when the upper data byte equals 0x5A. A write with any other upper byte leaves the register unchanged and pulses a fault output for one cycle. The lower byte holds the tap select, a self-clearing restart command, the interval-mode select and the hold control. Reads return 0x69 in the upper byte.

Software services the timer in one of two ways. It can acknowledge the interrupt, which clears the flag automatically. It can also write the flag register directly. Rewriting the control register with the restart bit set before the period ends keeps the flag from being set.

Top module: `interval_watchdog`

## Requirements
- R1: After reset, the control register reads 0x6900, the flag and enable registers read 0, irq_req is 0 and key_fault is 0.
- R2: A write to address 0x0120 whose upper data byte is not 0x5A leaves the control register unchanged. key_fault is 1 for exactly the one cycle that follows the write edge.
- R3: A read of 0x0120 returns 0x69 in bits [15:8] and the stored control bits in [7:0]. Bit 3 always reads 0.
- R4: Control bits [1:0] select the period: 2'b11 gives 64 clocks, 2'b10 gives 512, 2'b01 gives 8192 and 2'b00 gives 32768. The flag becomes 1 on the clock edge that lies exactly one period after a keyed write that sets bit 4 and bit 3.
- R5: A keyed control write with bit 3 set restarts the count from zero. Repeating that write before the period elapses delays the flag to one full period after the last such write.
- R6: While control bit 7 (hold) is 1, the counter does not advance and the flag is not set. After hold is cleared without a restart, counting resumes from the held value.
- R7: The flag (bit 0 of address 0x0002) is set when the period elapses, regardless of the enable. irq_req is 1 only when the flag and the enable (bit 0 of address 0x0000) are both 1.
- R8: A write of 0 to bit 0 of address 0x0002 clears the flag and drops irq_req.
- R9: In interval mode, irq_ack held high across a clock edge clears the flag at that edge.
- R10: While control bit 4 is 0, the counter does not advance and the flag is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Byte address for both reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq_ack | input | 1 | Interrupt acknowledge for the watchdog vector |
| irq_req | output | 1 | Interrupt request (flag AND enable) |
| key_fault | output | 1 | One-cycle pulse after a write with a bad key |

## Verification
The control register is written with four patterns (all ones, two alternating bit patterns and all zeros). These show that every stored bit is kept, that the restart bit never reads back, and that the read key replaces the write key. All four tap codes are run from a restart, and the flag is sampled one cycle before and at the predicted edge. This separates the periods and catches any off-by-one in the terminal-count detection. Further runs cover a restart in mid-period, hold followed by resume, a disabled mode and a bad key. Each of these must suppress or shift the flag while a plain run does not. Acknowledge, flag writes and enable toggling then show which of the flag and the enable gates the request.

// File: rtl/wdt_pkg.sv
// Shared constants for the keyed interval watchdog.
// Assumes byte addressing on a 16-bit register bus.
package wdt_pkg;
    localparam int          BUS_W     = 16;
    localparam int          CNT_W     = 16;
    localparam logic [15:0] ADDR_IE   = 16'h0000;
    localparam logic [15:0] ADDR_FLAG = 16'h0002;
    localparam logic [15:0] ADDR_CTRL = 16'h0120;
    localparam logic [7:0]  KEY_WRITE = 8'h5A;
    localparam logic [7:0]  KEY_READ  = 8'h69;

    // Control byte bit positions
    localparam int CB_HOLD  = 7;
    localparam int CB_MODE  = 4;
    localparam int CB_CLEAR = 3;

    // Counter bit whose roll-over ends the period for each tap code
    function automatic int tap_pos(input int code);
        case (code)
            3:       return 5;
            2:       return 8;
            1:       return 12;
            default: return 14;
        endcase
    endfunction
endpackage

// File: rtl/wdt_counter.sv
// Period counter: advances when run is high, restarts on clr.
// Raises tick in the cycle its low bits up to the selected tap are all ones.
// Assumes clr has priority over counting.
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clr,
    input  logic [1:0]   tap,
    output logic [W-1:0] cnt_q,
    output logic         tick
);
    localparam int NTAP = 4;

    logic [NTAP-1:0] hit;

    // One terminal-count detector per tap code
    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        localparam int P = tap_pos(g);
        assign hit[g] = &cnt_q[P:0];
    end

    // Selected period end, only while counting
    always_comb tick = run && !clr && hit[tap];

    // Counter register: restart beats increment
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdt_regs.sv
// Register file of the watchdog: keyed control, enable and flag.
// Decodes the bus, checks the write key and produces the restart pulse.
// Assumes one access per cycle; reads are combinational.
module wdt_regs
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] addr,
    input  logic             wr,
    input  logic [BUS_W-1:0] wdata,
    input  logic             tick,
    input  logic             ack,
    output logic [7:0]       ctrl_q,
    output logic             ie_q,
    output logic             flag_q,
    output logic             clr_pulse,
    output logic             key_fault,
    output logic [BUS_W-1:0] rdata
);
    logic sel_ctrl, sel_ie, sel_flag, key_ok, ctrl_wr, ack_ok;

    // Address and key decode
    always_comb begin
        sel_ctrl  = wr && (addr == ADDR_CTRL);
        sel_ie    = wr && (addr == ADDR_IE);
        sel_flag  = wr && (addr == ADDR_FLAG);
        key_ok    = (wdata[15:8] == KEY_WRITE);
        ctrl_wr   = sel_ctrl && key_ok;
        clr_pulse = ctrl_wr && wdata[CB_CLEAR];
        ack_ok    = ack && ctrl_q[CB_MODE];
    end

    // Control byte store; the restart bit is never kept
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= 8'h00;
        else if (ctrl_wr) ctrl_q <= wdata[7:0] & ~(8'h01 << CB_CLEAR);
    end

    // Bad-key pulse, one cycle after the offending write
    always_ff @(posedge clk) begin
        if (!rst_n) key_fault <= 1'b0;
        else        key_fault <= sel_ctrl && !key_ok;
    end

    // Interrupt enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)      ie_q <= 1'b0;
        else if (sel_ie) ie_q <= wdata[0];
    end

    // Interval flag: period end, then acknowledge, then software write
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (tick)     flag_q <= 1'b1;
        else if (ack_ok)   flag_q <= 1'b0;
        else if (sel_flag) flag_q <= wdata[0];
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL: rdata = {KEY_READ, ctrl_q};
            ADDR_FLAG: rdata = {{(BUS_W-1){1'b0}}, flag_q};
            ADDR_IE:   rdata = {{(BUS_W-1){1'b0}}, ie_q};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/interval_watchdog.sv
// Top of the keyed interval watchdog. Joins the register file and the
// period counter and forms the interrupt request.
// Assumes a single clock and synchronous active-low reset.
module interval_watchdog
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        irq_ack,
    output logic        irq_req,
    output logic        key_fault
);
    logic [7:0]       ctrl_q;
    logic             ie_q, flag_q, clr_pulse, tick, run;
    logic [CNT_W-1:0] cnt_q;

    // Count only in interval mode with hold released
    always_comb run = ctrl_q[CB_MODE] && !ctrl_q[CB_HOLD];

    wdt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
        .wdata(bus_wdata), .tick(tick), .ack(irq_ack), .ctrl_q(ctrl_q),
        .ie_q(ie_q), .flag_q(flag_q), .clr_pulse(clr_pulse),
        .key_fault(key_fault), .rdata(bus_rdata)
    );

    wdt_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(clr_pulse),
        .tap(ctrl_q[1:0]), .cnt_q(cnt_q), .tick(tick)
    );

    // Request toward the CPU
    always_comb irq_req = flag_q && ie_q;
endmodule

// File: rtl/wdt_checker.sv
// Property checker for interval_watchdog, bound into the top.
module wdt_checker
    import wdt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [15:0]      bus_addr,
    input logic             bus_wr,
    input logic [15:0]      bus_wdata,
    input logic             irq_ack,
    input logic             irq_req,
    input logic             key_fault,
    input logic [7:0]       ctrl_q,
    input logic             ie_q,
    input logic             flag_q,
    input logic             clr_pulse,
    input logic             tick,
    input logic [CNT_W-1:0] cnt_q
);
    logic bad_wr;
    always_comb bad_wr = bus_wr && bus_addr == ADDR_CTRL && bus_wdata[15:8] != KEY_WRITE;

    AST_BAD_KEY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> key_fault); // R2
    AST_BAD_KEY_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> $stable(ctrl_q)); // R2
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> cnt_q == '0); // R5
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CB_HOLD] && !clr_pulse |=> $stable(cnt_q)); // R6
    AST_HOLD_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CB_HOLD] && !flag_q && !(bus_wr && bus_addr == ADDR_FLAG) |=> !flag_q); // R6
    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[CB_MODE] && !clr_pulse |=> $stable(cnt_q)); // R10
    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_q |-> !irq_req); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack && ctrl_q[CB_MODE] && !tick && !(bus_wr && bus_addr == ADDR_FLAG) |=> !flag_q); // R9
endmodule

bind interval_watchdog wdt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .irq_ack(irq_ack), .irq_req(irq_req),
    .key_fault(key_fault), .ctrl_q(ctrl_q), .ie_q(ie_q), .flag_q(flag_q),
    .clr_pulse(clr_pulse), .tick(tick), .cnt_q(cnt_q)
);

// File: tb/sim_interval_watchdog.sv
`timescale 1ns/1ps
module sim_interval_watchdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_ack = 1'b0;
    logic        irq_req, key_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    interval_watchdog u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
        .irq_req(irq_req), .key_fault(key_fault)
    );

    // Control write patterns and their expected read-back
    localparam logic [31:0] VEC [4] = '{
        {16'h5AFF, 16'h69F7}, {16'h5A55, 16'h6955},
        {16'h5AAA, 16'h69A2}, {16'h5A00, 16'h6900}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write: drive at falling edge, commit on the next rising edge
    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic expect_flag(input string req, input logic exp);
        logic [15:0] v;
        bus_read(16'h0002, v);
        check(req, v, {15'd0, exp});
    endtask

    // Restart with a tap, then sample the flag around the expected edge
    task automatic run_period(input logic [1:0] tap, input int period, input string req);
        bus_write(16'h0002, 16'h0000);
        bus_write(16'h0120, {8'h5A, 8'h18 | {6'd0, tap}});
        repeat (period - 1) @(posedge clk);
        expect_flag(req, 1'b0);
        @(posedge clk);
        expect_flag(req, 1'b1);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        bus_read(16'h0120, v); check("R1 ctrl", v, 16'h6900);
        bus_read(16'h0002, v); check("R1 flag", v, 16'h0000);
        bus_read(16'h0000, v); check("R1 ie", v, 16'h0000);
        check("R1 irq", {15'd0, irq_req}, 16'h0000);
        check("R1 fault", {15'd0, key_fault}, 16'h0000);

        // R3 table of control patterns
        for (int i = 0; i < 4; i++) begin
            bus_write(16'h0120, VEC[i][31:16]);
            bus_read(16'h0120, v);
            check("R3 readback", v, VEC[i][15:0]);
        end

        // R2 bad key
        bus_write(16'h0120, 16'h5A13);
        bus_write(16'h0120, 16'h3C9A);
        check("R2 fault pulse", {15'd0, key_fault}, 16'h0001);
        @(posedge clk); #1;
        check("R2 fault ends", {15'd0, key_fault}, 16'h0000);
        bus_read(16'h0120, v); check("R2 unchanged", v, 16'h6913);

        // R4 all taps
        run_period(2'b11, 64, "R4 /64");
        run_period(2'b10, 512, "R4 /512");
        run_period(2'b01, 8192, "R4 /8192");
        run_period(2'b00, 32768, "R4 /32768");

        // R7 flag set with enable off, request only with enable
        check("R7 no irq without ie", {15'd0, irq_req}, 16'h0000);
        bus_write(16'h0000, 16'h0001);
        @(negedge clk);
        check("R7 irq with ie", {15'd0, irq_req}, 16'h0001);

        // R8 software clear
        bus_write(16'h0002, 16'h0000);
        expect_flag("R8 flag cleared", 1'b0);
        check("R8 irq dropped", {15'd0, irq_req}, 16'h0000);

        // R9 acknowledge clears flag
        run_period(2'b11, 64, "R9 setup");
        @(negedge clk); irq_ack = 1'b1;
        @(posedge clk); #1 irq_ack = 1'b0;
        expect_flag("R9 ack clear", 1'b0);
        check("R9 irq low", {15'd0, irq_req}, 16'h0000);

        // R5 restart before period end
        bus_write(16'h0002, 16'h0000);
        bus_write(16'h0120, 16'h5A1B);
        repeat (40) @(posedge clk);
        bus_write(16'h0120, 16'h5A1B);
        repeat (40) @(posedge clk);
        expect_flag("R5 postponed", 1'b0);
        repeat (23) @(posedge clk);
        expect_flag("R5 before edge", 1'b0);
        @(posedge clk);
        expect_flag("R5 after full period", 1'b1);

        // R6 hold freezes, then resume without restart
        bus_write(16'h0002, 16'h0000);
        bus_write(16'h0120, 16'h5A9B);
        repeat (200) @(posedge clk);
        expect_flag("R6 held", 1'b0);
        bus_write(16'h0120, 16'h5A13);
        repeat (63) @(posedge clk);
        expect_flag("R6 resume early", 1'b0);
        @(posedge clk);
        expect_flag("R6 resume", 1'b1);

        // R10 mode off: no counting
        bus_write(16'h0002, 16'h0000);
        bus_write(16'h0120, 16'h5A0B);
        repeat (200) @(posedge clk);
        expect_flag("R10 mode off", 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule